// File: doc/BRIEF.md
# Processor Supervisor with Watchdog and Supply Reset

This block watches over a host processor and drives a single reset line to it. Two sources can assert that reset. The first is a synchronous flag that reports the supply as below its threshold. The second is a watchdog timer. The host restarts the watchdog by pulling the shared chip-select/watchdog line from high to low. If it misses a restart, a timed reset pulse follows.

A small configuration register sets the watchdog period and holds a lock bit. While a write-protect pin is active, the lock bit freezes that register. All timing is counted in pulses of a millisecond tick input. A bench can therefore drive the tick every clock and use short periods set by parameter. A status output marks the resets that come from the watchdog. The output polarity is chosen by parameter.

Top module: `wdt_supervisor`

## Requirements
- R1: While `rstN` is low, reset is active. After `rstN` rises with the supply good, reset stays active for `HOLD_MS` ticks and then releases.
- R2: Reset is active from the first clock edge that samples `supplyLow` high, and stays active for as long as `supplyLow` stays high.
- R3: After `supplyLow` falls, reset stays active for a further `HOLD_MS` ticks and then releases.
- R4: The timeout field is `cfgWrData[1:0]`. Its codes are 00 = `TO_LONG_MS`, 01 = `TO_MID_MS` and 10 = `TO_SHORT_MS`. If no kick arrives within the selected number of ticks of the watchdog running, reset asserts.
- R5: Timeout code 11 disables the watchdog, so reset never asserts from it.
- R6: A kick is a falling edge of `csWdi`, seen after a two-flop synchronizer. It clears the watchdog count. A line held steadily high or steadily low gives no kick.
- R7: A watchdog reset lasts `HOLD_MS` ticks. `wdtTrip` is high exactly during that reset, and the watchdog then counts a fresh full period.
- R8: The watchdog count is held at zero during any supply or power-on reset. Counting starts only when that reset releases.
- R9: While `wpPin` is high and the lock bit is set, register writes are ignored, including writes that try to clear the lock bit.
- R10: A write with `cfgWrEn` high loads `cfgWrData[2]` as the lock bit and `cfgWrData[1:0]` as the timeout code. After `rstN` the code is 00 and the lock bit is 0.
- R11: `ACTIVE_LOW=1` drives `resetOut` low when active. `ACTIVE_LOW=0` drives it high when active.
- R12: Counts advance only on clocks where `msTick` is high. With no tick, reset never releases or asserts except through `supplyLow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| msTick | input | 1 | One-clock pulse per millisecond |
| supplyLow | input | 1 | Supply below threshold, synchronous |
| csWdi | input | 1 | Chip-select line; its falling edges kick the watchdog |
| wpPin | input | 1 | Write protect, active high |
| cfgWrEn | input | 1 | Register write strobe |
| cfgWrData | input | 3 | Bit 2 lock enable, bits 1:0 timeout code |
| resetOut | output | 1 | Reset to the host, polarity set by `ACTIVE_LOW` |
| wdtTrip | output | 1 | High while the reset comes from the watchdog |

## Verification
The bench builds the block with `HOLD_MS=6` and periods of 20, 13 and 9 ticks, and drives a tick on every clock. At these sizes it can sweep the kick offset across the whole window of each timeout code. That sweep covers a kick on the very last tick, where the kick must win over expiry. A second instance with `ACTIVE_LOW=0` shares every input, so the two polarities are compared on every cycle. With the short periods, the lock sequences, the tick-gating hold and the supply drops during a run or a watchdog pulse all fit in a few thousand cycles.

// File: rtl/wdt_sup_pkg.sv
package wdt_sup_pkg;

  typedef enum logic [1:0] {
    ST_PWR    = 2'd0,
    ST_RUN    = 2'd1,
    ST_WPULSE = 2'd2
  } supState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic holdClr;
    logic holdRun;
    logic wdtClr;
    logic wdtRun;
  } supStb_t;

  localparam logic [1:0] TO_CODE_OFF = 2'b11;

endpackage

// File: rtl/wdt_sup_dp.sv
module wdt_sup_dp
  import wdt_sup_pkg::*;
#(
  parameter int HOLD_MS     = 200,
  parameter int TO_LONG_MS  = 1400,
  parameter int TO_MID_MS   = 600,
  parameter int TO_SHORT_MS = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       csWdi,
  input  logic       wpPin,
  input  logic       cfgWrEn,
  input  logic [2:0] cfgWrData,
  input  supStb_t    stb,
  output logic       holdDone,
  output logic       wdtExpire
);

  localparam int MAX_A  = (TO_LONG_MS > TO_MID_MS) ? TO_LONG_MS : TO_MID_MS;
  localparam int MAX_B  = (TO_SHORT_MS > HOLD_MS) ? TO_SHORT_MS : HOLD_MS;
  localparam int MAX_MS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_MS + 1);

  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_MS - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(TO_LONG_MS - 1);
  localparam logic [CNT_W-1:0] MID_LAST   = CNT_W'(TO_MID_MS - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(TO_SHORT_MS - 1);

  // configuration register
  logic [1:0] cfgTo;
  logic       cfgLock;
  logic       wrAllowed;

  assign wrAllowed = cfgWrEn && !(wpPin && cfgLock);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgTo   <= 2'b00;
      cfgLock <= 1'b0;
    end else if (wrAllowed) begin
      cfgTo   <= cfgWrData[1:0];
      cfgLock <= cfgWrData[2];
    end
  end

  // two-flop synchronizer, then falling-edge detect
  logic csS1, csS2, csPrev, kick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csS1   <= 1'b1;
      csS2   <= 1'b1;
      csPrev <= 1'b1;
    end else begin
      csS1   <= csWdi;
      csS2   <= csS1;
      csPrev <= csS2;
    end
  end

  assign kick = csPrev && !csS2;

  // hold counter, shared by the power-on and watchdog resets
  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      holdCnt <= '0;
    else if (stb.holdClr)           holdCnt <= '0;
    else if (stb.holdRun && msTick) holdCnt <= holdCnt + 1'b1;
  end

  assign holdDone = stb.holdRun && !stb.holdClr && msTick && (holdCnt == HOLD_LAST);

  // watchdog counter
  logic [CNT_W-1:0] wdtCnt;
  logic [CNT_W-1:0] wdtLast;
  logic             wdtOn;

  always_comb begin
    unique case (cfgTo)
      2'b00:   wdtLast = LONG_LAST;
      2'b01:   wdtLast = MID_LAST;
      default: wdtLast = SHORT_LAST;
    endcase
  end

  assign wdtOn = (cfgTo != TO_CODE_OFF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                wdtCnt <= '0;
    else if (stb.wdtClr || kick || !wdtOn)    wdtCnt <= '0;
    else if (stb.wdtRun && msTick)            wdtCnt <= wdtCnt + 1'b1;
  end

  assign wdtExpire = stb.wdtRun && !stb.wdtClr && wdtOn && !kick && msTick
                     && (wdtCnt == wdtLast);

endmodule

// File: rtl/wdt_sup_ctrl.sv
module wdt_sup_ctrl
  import wdt_sup_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    supplyLow,
  input  logic    holdDone,
  input  logic    wdtExpire,
  output supStb_t stb,
  output logic    resetAsserted,
  output logic    wdtCause
);

  supState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PWR;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      ST_RUN: begin
        stb.holdClr = 1'b1;
        stb.wdtRun  = 1'b1;
        if (supplyLow)      stateNext = ST_PWR;
        else if (wdtExpire) stateNext = ST_WPULSE;
      end
      ST_WPULSE: begin
        stb.wdtClr = 1'b1;
        if (supplyLow) begin
          stb.holdClr = 1'b1;
          stateNext   = ST_PWR;
        end else begin
          stb.holdRun = 1'b1;
          if (holdDone) stateNext = ST_RUN;
        end
      end
      default: begin
        stb.wdtClr = 1'b1;
        if (supplyLow) stb.holdClr = 1'b1;
        else begin
          stb.holdRun = 1'b1;
          if (holdDone) stateNext = ST_RUN;
        end
      end
    endcase
  end

  assign resetAsserted = (state != ST_RUN);
  assign wdtCause      = (state == ST_WPULSE);

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
  import wdt_sup_pkg::*;
#(
  parameter int HOLD_MS     = 200,
  parameter int TO_LONG_MS  = 1400,
  parameter int TO_MID_MS   = 600,
  parameter int TO_SHORT_MS = 200,
  parameter bit ACTIVE_LOW  = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       supplyLow,
  input  logic       csWdi,
  input  logic       wpPin,
  input  logic       cfgWrEn,
  input  logic [2:0] cfgWrData,
  output logic       resetOut,
  output logic       wdtTrip
);

  supStb_t stb;
  logic    holdDone, wdtExpire, resetAsserted;

  wdt_sup_dp #(
    .HOLD_MS(HOLD_MS), .TO_LONG_MS(TO_LONG_MS),
    .TO_MID_MS(TO_MID_MS), .TO_SHORT_MS(TO_SHORT_MS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .msTick(msTick), .csWdi(csWdi), .wpPin(wpPin),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .stb(stb),
    .holdDone(holdDone), .wdtExpire(wdtExpire)
  );

  wdt_sup_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .supplyLow(supplyLow), .holdDone(holdDone),
    .wdtExpire(wdtExpire), .stb(stb), .resetAsserted(resetAsserted),
    .wdtCause(wdtTrip)
  );

  generate
    if (ACTIVE_LOW) begin : g_low
      assign resetOut = !resetAsserted;
    end else begin : g_high
      assign resetOut = resetAsserted;
    end
  endgenerate

endmodule

// File: rtl/wdt_sup_chk.sv
module wdt_sup_chk #(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input logic clk,
  input logic rstN,
  input logic msTick,
  input logic supplyLow,
  input logic resetOut,
  input logic wdtTrip
);

  logic resetActive;
  assign resetActive = ACTIVE_LOW ? !resetOut : resetOut;

  assert_rst_on_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |=> resetActive);

  assert_hold_after_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(supplyLow) |-> resetActive);

  assert_trip_in_reset_R7: assert property (@(posedge clk) disable iff (!rstN)
    wdtTrip |-> resetActive);

  assert_trip_from_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdtTrip) |-> !$past(resetActive));

  assert_tick_gate_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(msTick) && !$past(supplyLow)) |-> $stable(resetOut));

endmodule

bind wdt_supervisor wdt_sup_chk #(.ACTIVE_LOW(ACTIVE_LOW)) u_chk (
  .clk(clk), .rstN(rstN), .msTick(msTick), .supplyLow(supplyLow),
  .resetOut(resetOut), .wdtTrip(wdtTrip)
);

// File: tb/wdt_supervisor_tb.sv
`timescale 1ns/1ps
module wdt_supervisor_tb;

  localparam int H  = 6;
  localparam int TL = 20;
  localparam int TM = 13;
  localparam int TS = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b1;
  logic supplyLow = 1'b0;
  logic csWdi = 1'b1;
  logic wpPin = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [2:0] cfgWrData = 3'b000;
  logic resetN, resetHi, tripLo, tripHi;

  int nChecks = 0;
  int nFails = 0;
  int polMis = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_supervisor #(.HOLD_MS(H), .TO_LONG_MS(TL), .TO_MID_MS(TM), .TO_SHORT_MS(TS),
                   .ACTIVE_LOW(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .supplyLow(supplyLow), .csWdi(csWdi),
    .wpPin(wpPin), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .resetOut(resetN), .wdtTrip(tripLo));

  wdt_supervisor #(.HOLD_MS(H), .TO_LONG_MS(TL), .TO_MID_MS(TM), .TO_SHORT_MS(TS),
                   .ACTIVE_LOW(1'b0)) u_dutHi (
    .clk(clk), .rstN(rstN), .msTick(msTick), .supplyLow(supplyLow), .csWdi(csWdi),
    .wpPin(wpPin), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .resetOut(resetHi), .wdtTrip(tripHi));

  always @(negedge clk) if (resetHi !== ~resetN || tripHi !== tripLo) polMis++;

  function automatic bit active();
    return resetN == 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [2:0] d);
    @(negedge clk);
    cfgWrData = d;
    cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic untilRelease(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (active() && n < 400);
  endtask

  task automatic untilAssert(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!active() && n < 400);
  endtask

  // supply drop, then release; expect the hold period
  task automatic supplyCycle(input string req);
    int n;
    @(negedge clk); supplyLow = 1'b1;
    cycles(3);
    check(active(), "R2", int'(active()), 1);
    supplyLow = 1'b0;
    untilRelease(n);
    check(n == H, req, n, H);
  endtask

  function automatic int periodOf(input int code);
    return (code == 0) ? TL : (code == 1) ? TM : TS;
  endfunction

  initial begin : watchdogTimer
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    int n;
    cycles(3);
    // R1 reset state while rstN low
    check(active() && !tripLo, "R1", int'(active()), 1);
    rstN = 1'b1;
    untilRelease(n);
    check(n == H, "R1", n, H);
    // R10 default code 00, R6 steady high gives no kick, R8 full period
    untilAssert(n);
    check(n == TL, "R10", n, TL);
    check(tripLo, "R7", int'(tripLo), 1);

    // sweep over the codes and every kick offset
    for (int code = 0; code < 3; code++) begin
      for (int k = 0; k + 3 <= periodOf(code); k++) begin
        @(negedge clk); supplyLow = 1'b1; csWdi = 1'b1;
        cfgWrite(3'(code));
        cycles(2);
        supplyLow = 1'b0;
        untilRelease(n);
        check(n == H, "R3", n, H);
        cycles(k);
        csWdi = 1'b0;
        untilAssert(n);
        check(n == periodOf(code) + 3, "R6", n, periodOf(code) + 3);
        check(tripLo, "R7", int'(tripLo), 1);
        untilRelease(n);
        check(n == H, "R7", n, H);
        check(!tripLo, "R7", int'(tripLo), 0);
        // line held low: no further kick; fresh full period
        untilAssert(n);
        check(n == periodOf(code), "R4", n, periodOf(code));
      end
    end

    // R8: supply drop mid-run clears the watchdog count
    @(negedge clk); supplyLow = 1'b1; csWdi = 1'b1;
    cfgWrite(3'b001);
    supplyLow = 1'b0;
    untilRelease(n);
    cycles(TM - 3);
    supplyCycle("R3");
    untilAssert(n);
    check(n == TM, "R8", n, TM);
    // supply drop during watchdog pulse
    @(negedge clk); supplyLow = 1'b1;
    @(negedge clk);
    check(active() && !tripLo, "R2", int'(tripLo), 0);
    supplyLow = 1'b0;
    untilRelease(n);
    check(n == H, "R3", n, H);

    // R5 disabled watchdog
    @(negedge clk); supplyLow = 1'b1;
    cfgWrite(3'b011);
    supplyLow = 1'b0;
    untilRelease(n);
    cycles(3 * TL);
    check(!active(), "R5", int'(active()), 0);

    // R12 no tick: reset never releases
    @(negedge clk); supplyLow = 1'b1; msTick = 1'b0;
    cycles(2);
    supplyLow = 1'b0;
    cycles(40);
    check(active(), "R12", int'(active()), 1);
    msTick = 1'b1;
    untilRelease(n);
    check(n == H, "R12", n, H);

    // R9 lock: set lock with short code, then blocked writes
    @(negedge clk); supplyLow = 1'b1; wpPin = 1'b1;
    cfgWrite(3'b110);
    cfgWrite(3'b000);
    cfgWrite(3'b011);
    supplyLow = 1'b0;
    untilRelease(n);
    untilAssert(n);
    check(n == TS, "R9", n, TS);
    // R10 unlocked writes take effect
    @(negedge clk); supplyLow = 1'b1; wpPin = 1'b0;
    cfgWrite(3'b000);
    wpPin = 1'b1;
    cfgWrite(3'b001);
    supplyLow = 1'b0;
    untilRelease(n);
    untilAssert(n);
    check(n == TM, "R10", n, TM);
    wpPin = 1'b0;

    cycles(4);
    check(polMis == 0, "R11", polMis, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule